// File: doc/BRIEF.md
# Cache refresh grant handshake controller

This block is the controller end of a single shared, tri-stated refresh handshake wire between a memory controller and a second-level cache built from DRAM-based SRAM devices. When reset is released it looks at the wire once. A high level means the cache needs refresh service. A low level, which is what the weak pull-down gives on an unconnected wire, leaves the block permanently inert. No register bit selects this mode.

In refresh mode the block listens for a request from the master cache device. A request is a two-clock pulse, low and then high, followed by release of the wire. The block answers with a grant pulse of the same shape. It sends the grant only after the requester has released the wire, and only in the clock that follows a clock in which the host bus was idle. Cache-busy stays high for the two grant clocks and for the whole refresh window after them, so that cache accesses are held off. A request that completes while a grant or refresh is still running is remembered and answered after cache-busy drops.

Top module: `l2rf_handshake_ctl`

## Requirements
- R1: The mode is taken from `line_in` at the first rising clock edge where `rst_n` is high. A 1 enables refresh mode, and that choice holds until the next reset.
- R2: If `line_in` was 0 at that edge, `line_oe` and `cache_busy` stay 0 for any later activity on the wire or on `bus_idle`.
- R3: While `rst_n` is low, `line_oe` and `cache_busy` are 0.
- R4: A request is `line_in` at 0 for one clock and at 1 in the next clock, and the clock after that is the release clock. A 0 that is followed by another 0 is ignored and causes no grant. Detection is suspended while the block drives the wire.
- R5: A grant starts only in the clock after a clock in which a request was pending and `bus_idle` was 1. If the request's low clock is clock c and `bus_idle` is 1 in c+3, the grant's low clock is c+4. While `bus_idle` stays 0 no grant starts.
- R6: A grant is `line_oe`=1 with `line_out`=0 for one clock, then `line_oe`=1 with `line_out`=1 for one clock, then `line_oe`=0.
- R7: `cache_busy` rises in the grant's low clock and stays high for exactly REFRESH_CLKS+2 clocks (22 by default): the two grant clocks plus 20 refresh clocks.
- R8: A request that completes while `cache_busy` is high is held. It is granted once `cache_busy` has fallen, at the first clock that follows an idle-bus clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| line_in | input | 1 | Sampled level of the shared handshake wire |
| line_oe | output | 1 | Output enable of the controller's wire driver |
| line_out | output | 1 | Value driven onto the wire while `line_oe` is 1 |
| bus_idle | input | 1 | High in a clock where the host bus has no activity |
| cache_busy | output | 1 | High while a grant or cache refresh is in progress |

## Verification
The bound checker checks on every clock that the driver is off just after reset, that each grant pulse has the low-high-release shape, that a grant starts only after an idle-bus clock, that cache-busy covers the grant, and that each busy window has the full length. It cannot see whether the mode was latched correctly, whether a malformed pulse was rejected, or whether a request that overlapped a refresh was kept. The bench shows those through its scenarios: grant counts after directed and random request traffic, and a per-cycle comparison with a bench model, all with a pulled wire whose resting level is set by the strap.

// File: rtl/l2rf_pkg.sv
// Shared state types for the cache refresh handshake controller.
package l2rf_pkg;
    // Request pulse recogniser progress.
    typedef enum logic [1:0] {
        DET_IDLE = 2'd0,
        DET_LOW  = 2'd1,
        DET_HIGH = 2'd2
    } det_st_t;

    // Grant and refresh window progress.
    typedef enum logic [1:0] {
        GR_IDLE = 2'd0,
        GR_LOW  = 2'd1,
        GR_HIGH = 2'd2,
        GR_REF  = 2'd3
    } gr_st_t;
endpackage

// File: rtl/l2rf_mode_latch.sv
// Latches the refresh-mode strap from the handshake wire at the first clock
// after reset release. Assumes the wire rests at its strap level during reset.
module l2rf_mode_latch (
    input  logic clk,
    input  logic rst_n,
    input  logic line_in,
    output logic mode_en
);
    logic armed_q;

    // Capture the wire level once per reset release and hold it.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            armed_q <= 1'b0;
            mode_en <= 1'b0;
        end else if (!armed_q) begin
            armed_q <= 1'b1;
            mode_en <= line_in;
        end
    end
endmodule

// File: rtl/l2rf_req_detect.sv
// Recognises a low-then-high request pulse on the handshake wire. req_done is
// high in the release clock that follows the high clock. Assumes the caller
// deasserts enable while this side drives the wire.
module l2rf_req_detect
    import l2rf_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic enable,
    input  logic line_in,
    output logic req_done
);
    det_st_t st_q;

    // Step through the pulse shape, and drop malformed or interrupted pulses.
    always_ff @(posedge clk) begin
        if (!rst_n || !enable) begin
            st_q <= DET_IDLE;
        end else begin
            case (st_q)
                DET_IDLE: st_q <= line_in ? DET_IDLE : DET_LOW;
                DET_LOW:  st_q <= line_in ? DET_HIGH : DET_IDLE;
                default:  st_q <= DET_IDLE;
            endcase
        end
    end

    // Request complete in the release clock.
    always_comb req_done = (st_q == DET_HIGH);
endmodule

// File: rtl/l2rf_grant_fsm.sv
// Holds pending requests, issues the grant pulse after an idle bus clock, and
// times the refresh window. Assumes req_done is a one-clock strobe.
module l2rf_grant_fsm
    import l2rf_pkg::*;
#(
    parameter int REFRESH_CLKS = 20
) (
    input  logic clk,
    input  logic rst_n,
    input  logic mode_en,
    input  logic req_done,
    input  logic bus_idle,
    output logic line_oe,
    output logic line_out,
    output logic cache_busy
);
    localparam int CNT_W = $clog2(REFRESH_CLKS + 1);
    localparam logic [CNT_W-1:0] REF_LAST = CNT_W'(REFRESH_CLKS - 1);

    gr_st_t           st_q;
    logic [CNT_W-1:0] cnt_q;
    logic             pend_q;
    logic             grant_go;

    // A grant may start from idle when a request waits and the bus was idle.
    always_comb grant_go = mode_en && pend_q && bus_idle && (st_q == GR_IDLE);

    // Remember a finished request until its grant starts.
    always_ff @(posedge clk) begin
        if (!rst_n) pend_q <= 1'b0;
        else        pend_q <= (pend_q && !grant_go) || req_done;
    end

    // Sequence the grant pulse and the refresh window.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q  <= GR_IDLE;
            cnt_q <= '0;
        end else begin
            case (st_q)
                GR_IDLE: if (grant_go) st_q <= GR_LOW;
                GR_LOW:  st_q <= GR_HIGH;
                GR_HIGH: begin
                    st_q  <= GR_REF;
                    cnt_q <= REF_LAST;
                end
                default: begin
                    if (cnt_q == '0) st_q <= GR_IDLE;
                    else             cnt_q <= cnt_q - 1'b1;
                end
            endcase
        end
    end

    // Drive the wire during the grant pulse and flag busy while not idle.
    always_comb begin
        line_oe    = (st_q == GR_LOW) || (st_q == GR_HIGH);
        line_out   = (st_q == GR_HIGH);
        cache_busy = (st_q != GR_IDLE);
    end
endmodule

// File: rtl/l2rf_handshake_ctl.sv
// Controller side of the cache refresh handshake wire. Latches the mode strap,
// detects requests, and answers with grants while gating cache access.
// Assumes an external tri-state pad that merges line_oe/line_out into line_in.
module l2rf_handshake_ctl #(
    parameter int REFRESH_CLKS = 20
) (
    input  logic clk,
    input  logic rst_n,
    input  logic line_in,
    output logic line_oe,
    output logic line_out,
    input  logic bus_idle,
    output logic cache_busy
);
    logic mode_en;
    logic det_en;
    logic req_done;

    l2rf_mode_latch u_mode (
        .clk     (clk),
        .rst_n   (rst_n),
        .line_in (line_in),
        .mode_en (mode_en)
    );

    // Listen only in refresh mode and never to our own drive.
    always_comb det_en = mode_en && !line_oe;

    l2rf_req_detect u_det (
        .clk      (clk),
        .rst_n    (rst_n),
        .enable   (det_en),
        .line_in  (line_in),
        .req_done (req_done)
    );

    l2rf_grant_fsm #(.REFRESH_CLKS(REFRESH_CLKS)) u_grant (
        .clk        (clk),
        .rst_n      (rst_n),
        .mode_en    (mode_en),
        .req_done   (req_done),
        .bus_idle   (bus_idle),
        .line_oe    (line_oe),
        .line_out   (line_out),
        .cache_busy (cache_busy)
    );
endmodule

// File: rtl/l2rf_handshake_ctl_chk.sv
// Protocol checker for the handshake controller, bound to its top module.
module l2rf_handshake_ctl_chk #(
    parameter int REFRESH_CLKS = 20
) (
    input logic clk,
    input logic rst_n,
    input logic line_in,
    input logic line_oe,
    input logic line_out,
    input logic bus_idle,
    input logic cache_busy
);
    localparam int RUN_W = $clog2(REFRESH_CLKS + 3) + 1;

    logic [RUN_W-1:0] run_q;

    // Length of the current busy run.
    always_ff @(posedge clk) begin
        if (!rst_n)          run_q <= '0;
        else if (cache_busy) run_q <= run_q + 1'b1;
        else                 run_q <= '0;
    end

    AST_QUIET_AFTER_RESET: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!rst_n) |-> (!line_oe && !cache_busy)); // R3
    AST_GRANT_LOW_THEN_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        (line_oe && !line_out) |=> (line_oe && line_out)); // R6
    AST_GRANT_HIGH_THEN_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        (line_oe && line_out) |=> !line_oe); // R6
    AST_GRANT_AFTER_IDLE_BUS: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(line_oe) |-> ($past(bus_idle) && !line_out)); // R5
    AST_BUSY_COVERS_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
        line_oe |-> cache_busy); // R7
    AST_BUSY_FULL_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(cache_busy) |-> (run_q == RUN_W'(REFRESH_CLKS + 2))); // R7
endmodule

bind l2rf_handshake_ctl l2rf_handshake_ctl_chk #(.REFRESH_CLKS(REFRESH_CLKS)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .line_in    (line_in),
    .line_oe    (line_oe),
    .line_out   (line_out),
    .bus_idle   (bus_idle),
    .cache_busy (cache_busy)
);

// File: tb/l2rf_handshake_ctl_test.sv
// Bench: pulled handshake wire, a master cache device model, directed and
// seeded random request traffic, compared against a cycle model in the bench.
module l2rf_handshake_ctl_test;
    localparam int CLK_PERIOD = 10;
    localparam int REF_CLKS   = 20;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic bus_idle = 1'b1;
    logic sram_oe = 1'b0;
    logic sram_v = 1'b0;
    logic strap = 1'b1;
    logic line_oe, line_out, cache_busy;
    wire  line_w = line_oe ? line_out : (sram_oe ? sram_v : strap);

    int n_chk = 0;
    int n_fail = 0;
    int grants = 0;
    int busy_seen = 0;
    int run = 0;
    logic prev_oe = 1'b0;

    // Bench model state
    bit m_valid = 0, m_armed = 0, m_mode = 0, m_pend = 0;
    int m_det = 0, m_g = 0, m_cnt = 0;

    l2rf_handshake_ctl #(.REFRESH_CLKS(REF_CLKS)) uut (
        .clk(clk), .rst_n(rst_n), .line_in(line_w), .line_oe(line_oe),
        .line_out(line_out), .bus_idle(bus_idle), .cache_busy(cache_busy)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic bit exp_oe();  return (m_g == 1) || (m_g == 2); endfunction
    function automatic bit exp_out(); return (m_g == 2); endfunction
    function automatic bit exp_busy(); return (m_g != 0); endfunction

    // Advance the model from the inputs seen during this clock.
    task automatic model_step(input logic rs, input logic ln, input logic bi);
        bit done, go, old_mode;
        if (!rs) begin
            m_armed = 0; m_mode = 0; m_pend = 0; m_det = 0; m_g = 0; m_cnt = 0;
            m_valid = 1;
            return;
        end
        old_mode = m_mode;
        if (!m_armed) begin m_armed = 1; m_mode = ln; end
        done = (m_det == 2);
        go   = old_mode && m_pend && bi && (m_g == 0);
        if (!old_mode || exp_oe()) m_det = 0;
        else if (m_det == 0) m_det = ln ? 0 : 1;
        else if (m_det == 1) m_det = ln ? 2 : 0;
        else m_det = 0;
        m_pend = (m_pend && !go) || done;
        case (m_g)
            0: if (go) m_g = 1;
            1: m_g = 2;
            2: begin m_g = 3; m_cnt = REF_CLKS - 1; end
            default: if (m_cnt == 0) m_g = 0; else m_cnt--;
        endcase
    endtask

    // One clock: observe outputs, apply the next inputs, advance the model.
    task automatic cyc(input logic so, input logic sv, input logic bi, input logic rs);
        @(negedge clk);
        if (m_valid) begin
            chk(line_oe == exp_oe(), "R6 line_oe vs model", line_oe, exp_oe());
            if (line_oe) chk(line_out == exp_out(), "R6 line_out vs model", line_out, exp_out());
            chk(cache_busy == exp_busy(), "R7 cache_busy vs model", cache_busy, exp_busy());
        end
        if (line_oe && !prev_oe) begin
            grants++;
            chk(bus_idle == 1'b1, "R5 idle bus before grant", bus_idle, 1);
        end
        prev_oe = line_oe;
        if (cache_busy) begin run++; busy_seen++; end
        else if (run != 0) begin
            chk(run == REF_CLKS + 2, "R7 busy window length", run, REF_CLKS + 2);
            run = 0;
        end
        sram_oe = so; sram_v = sv; bus_idle = bi; rst_n = rs;
        #1;
        model_step(rs, line_w, bi);
    endtask

    task automatic idle_n(input int n, input logic bi);
        for (int i = 0; i < n; i++) cyc(1'b0, 1'b0, bi, 1'b1);
    endtask

    task automatic request(input logic bi);
        cyc(1'b1, 1'b0, bi, 1'b1);
        cyc(1'b1, 1'b1, bi, 1'b1);
        cyc(1'b0, 1'b0, bi, 1'b1);
    endtask

    task automatic do_reset(input logic s);
        strap = s;
        for (int i = 0; i < 4; i++) cyc(1'b0, 1'b0, 1'b1, 1'b0);
        cyc(1'b0, 1'b0, 1'b1, 1'b0);
        chk(line_oe == 1'b0, "R3 no drive in reset", line_oe, 0);
        chk(cache_busy == 1'b0, "R3 not busy in reset", cache_busy, 0);
        cyc(1'b0, 1'b0, 1'b1, 1'b1);
    endtask

    initial begin : watchdog
        #(CLK_PERIOD * 200000);
        n_fail++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin : stim
        int g0, gap;
        void'($urandom(32'h1F2E3D4C));

        // R1 and R3: refresh mode selected by a high strap.
        do_reset(1'b1);
        idle_n(3, 1'b1);
        g0 = grants;
        request(1'b1);
        idle_n(1, 1'b1);
        // Grant low clock is two clocks after release: c+4.
        cyc(1'b0, 1'b0, 1'b1, 1'b1);
        chk(line_oe && !line_out, "R5 grant low at c+4", line_oe, 1);
        idle_n(30, 1'b1);
        chk(grants == g0 + 1, "R1 one grant in refresh mode", grants, g0 + 1);

        // R5: a busy host bus holds the grant back.
        g0 = grants;
        request(1'b0);
        idle_n(10, 1'b0);
        chk(grants == g0, "R5 no grant while bus busy", grants, g0);
        chk(cache_busy == 1'b0, "R5 not busy while waiting", cache_busy, 0);
        idle_n(30, 1'b1);
        chk(grants == g0 + 1, "R5 grant after idle bus", grants, g0 + 1);

        // R4: low followed by low is malformed.
        g0 = grants;
        cyc(1'b1, 1'b0, 1'b1, 1'b1);
        cyc(1'b1, 1'b0, 1'b1, 1'b1);
        cyc(1'b0, 1'b0, 1'b1, 1'b1);
        idle_n(30, 1'b1);
        chk(grants == g0, "R4 malformed pulse ignored", grants, g0);

        // R8: request completing during refresh is held.
        g0 = grants;
        request(1'b1);
        idle_n(8, 1'b1);
        chk(cache_busy == 1'b1, "R8 refresh running", cache_busy, 1);
        request(1'b1);
        idle_n(60, 1'b1);
        chk(grants == g0 + 2, "R8 held request granted", grants, g0 + 2);

        // Random traffic against the model.
        for (int k = 0; k < 60; k++) begin
            gap = int'($urandom % 10) + 1;
            for (int i = 0; i < gap; i++) cyc(1'b0, 1'b0, 1'($urandom % 3 != 0), 1'b1);
            while (!(m_pend == 0 && (m_g == 0 || (m_g == 3 && m_cnt > 3))))
                cyc(1'b0, 1'b0, 1'($urandom % 2), 1'b1);
            if ($urandom % 6 == 0) begin
                cyc(1'b1, 1'b0, 1'b1, 1'b1);
                cyc(1'b1, 1'b0, 1'b1, 1'b1);
                cyc(1'b0, 1'b0, 1'b1, 1'b1);
            end else begin
                request(1'($urandom % 2));
            end
        end
        idle_n(60, 1'b1);

        // R2: low strap leaves the block inert.
        do_reset(1'b0);
        busy_seen = 0;
        g0 = grants;
        for (int k = 0; k < 5; k++) begin
            request(1'b1);
            idle_n(5, 1'b1);
        end
        idle_n(30, 1'b1);
        chk(grants == g0, "R2 no grant without refresh mode", grants, g0);
        chk(busy_seen == 0, "R2 never busy without refresh mode", busy_seen, 0);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule